// File: doc/BRIEF.md
# Host-Clocked Serial Slave with Ready Handshake

This block is the serial front end of a peripheral that never speaks unless spoken to. A host drives the clock, the data-in line and an active-low select. The block samples incoming data on rising clock edges, most significant bit first, and hands each completed eight-bit command to the core logic beside it. At the same moment it pulls its open-drain ready line low, so the host knows to hold off. The core reads the command, optionally writes a response byte, then acknowledges. Only then is the ready line released. On the following transfer the stored response is shifted back to the host on the data-out line, which changes on falling clock edges and is only driven while the host holds select low. If nothing was written, zeros go out.

All host lines are asynchronous to the block's system clock. They pass through synchronizer flops and edge detectors, so the system clock must run at least eight times faster than the serial clock. The block also owns the choice between this serial port and a separate asynchronous receive line. Whichever of the two shows activity first after reset is locked in. The other stays dead until the next reset.

Top module: `spi_ready_slave`

## Requirements
- R1: After reset, rdy_pull_low is 0 (ready released), cmd_valid is 0, spi_miso_oe is 0, and neither if_spi nor if_uart is set.
- R2: While spi_ss_n is low and the serial port is selected, spi_mosi is sampled on each rising spi_sck edge, most significant bit first. After the eighth bit, cmd_valid rises and cmd_byte holds the eight sampled bits in order.
- R3: rdy_pull_low (1 = drive the line low, 0 = release it to the pull-up) goes to 1 after every complete byte. It stays 1 until cmd_ack is pulsed, and it is 0 in the cycle after the acknowledge.
- R4: A byte written through rsp_we/rsp_byte is sent on spi_miso during the next transfer, most significant bit first. Each bit is valid from one falling spi_sck edge up to the next rising edge. The response is consumed by the first falling spi_sck edge of that transfer.
- R5: If no response has been written since the last one was consumed, the transfer sends 0x00.
- R6: spi_miso_oe is 0 whenever spi_ss_n is high, and 1 while it is low with the serial port selected.
- R7: If spi_ss_n rises before the eighth bit, the partial bits are discarded: cmd_valid and rdy_pull_low stay 0, and the next full transfer is received aligned from its first bit.
- R8: A falling spi_ss_n while nothing is locked sets if_spi. This choice persists, and later uart_rx activity does not change it.
- R9: A falling uart_rx while nothing is locked sets if_uart. After that, serial transfers produce no cmd_valid and leave spi_miso_oe at 0.
- R10: If spi_ss_n and uart_rx fall in the same cycle while nothing is locked, the serial port is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host, idles high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_ss_n | input | 1 | Active-low select from the host, idles high |
| uart_rx | input | 1 | Asynchronous receive line; watched only for first activity |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (0 = high impedance) |
| rdy_pull_low | output | 1 | Open-drain ready control: 1 pulls the line low |
| cmd_valid | output | 1 | A received command is waiting for the core |
| cmd_byte | output | 8 | The received command |
| cmd_ack | input | 1 | Core pulse: command consumed, release ready |
| rsp_we | input | 1 | Core pulse: store rsp_byte as the pending response |
| rsp_byte | input | 8 | Response value from the core |
| if_spi | output | 1 | Serial port has been locked in |
| if_uart | output | 1 | Asynchronous receive line has been locked in |

## Verification
The bench first checks the start of a transfer. A design that shifts on the first falling edge instead of loading there would send the response rotated by one bit, and a random response stream exposes that at once. It then aborts transfers after one to seven bits and follows each with a full byte. A bit counter that is not cleared on select rising would deliver a misaligned command or raise ready falsely. Responses are skipped at random, so a design that fails to clear its pending flag would resend stale data where zeros are due. Three separate resets exercise the interface lock: receive line first, select first, and both together. A lock that is not sticky, or that gives the wrong one priority, shows up as a wrong flag or as a command accepted on the muted port.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;

  typedef enum logic [1:0] {
    IF_NONE = 2'd0,
    IF_SPI  = 2'd1,
    IF_UART = 2'd2
  } if_sel_e;

  function automatic logic edge_up(input logic now_v, input logic prev_v);
    return now_v & ~prev_v;
  endfunction

  function automatic logic edge_dn(input logic now_v, input logic prev_v);
    return ~now_v & prev_v;
  endfunction

  // Chooses the byte to shift out: pending response or zero fill.
  function automatic logic [7:0] tx_pick(input logic pend, input logic [7:0] val);
    return pend ? val : 8'h00;
  endfunction

endpackage

// File: rtl/spi_rdy_sync.sv
module spi_rdy_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  import spi_rdy_pkg::*;

  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      prev_q <= pipe[STAGES-1];
    end
  end

  assign lvl = pipe[STAGES-1];

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign rise[b] = edge_up(pipe[STAGES-1][b], prev_q[b]);
    assign fall[b] = edge_dn(pipe[STAGES-1][b], prev_q[b]);
  end

endmodule

// File: rtl/spi_rdy_lock.sv
module spi_rdy_lock (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_act,
  input  logic                 uart_act,
  output spi_rdy_pkg::if_sel_e sel
);
  import spi_rdy_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= IF_NONE;
    end else if (sel == IF_NONE) begin
      if (spi_act)       sel <= IF_SPI;
      else if (uart_act) sel <= IF_UART;
    end
  end

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != IF_NONE) |=> (sel == $past(sel))); // R8

  AST_SPI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == IF_NONE && spi_act) |=> (sel == IF_SPI)); // R10

endmodule

// File: rtl/spi_rdy_shift.sv
module spi_rdy_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_src,
  output logic              rx_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              tx_load,
  output logic              miso
);
  localparam int CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     bitcnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;

  assign rx_done = active & sck_rise & (bitcnt == LAST);
  assign rx_byte = {rx_sh[BYTE_W-2:0], mosi_s};
  assign tx_load = active & sck_fall & (bitcnt == '0);
  assign miso    = tx_sh[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_sh  <= '0;
      tx_sh  <= '0;
    end else if (!active) begin
      bitcnt <= '0;
    end else begin
      if (sck_rise) begin
        rx_sh  <= {rx_sh[BYTE_W-2:0], mosi_s};
        bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + CW'(1);
      end
      if (sck_fall) begin
        if (bitcnt == '0) tx_sh <= tx_src;
        else              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  AST_PARTIAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (bitcnt == '0)); // R7

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (miso == $past(tx_src[BYTE_W-1]))); // R4

endmodule

// File: rtl/spi_ready_slave.sv
module spi_ready_slave (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_mosi,
  input  logic       spi_ss_n,
  input  logic       uart_rx,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  output logic       rdy_pull_low,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  input  logic       cmd_ack,
  input  logic       rsp_we,
  input  logic [7:0] rsp_byte,
  output logic       if_spi,
  output logic       if_uart
);
  import spi_rdy_pkg::*;

  localparam int BYTE_W = 8;
  localparam int NSYNC  = 4;
  localparam int I_SCK  = 0;
  localparam int I_MOSI = 1;
  localparam int I_SS   = 2;
  localparam int I_URX  = 3;

  logic [NSYNC-1:0] s_lvl, s_rise, s_fall;
  if_sel_e          sel;
  logic             active, rx_done, tx_load;
  logic [BYTE_W-1:0] rx_byte, tx_src;
  logic [BYTE_W-1:0] rsp_q;
  logic              rsp_pend;

  spi_rdy_sync #(.W(NSYNC), .STAGES(2), .RST_VAL('1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({uart_rx, spi_ss_n, spi_mosi, spi_sck}),
    .lvl  (s_lvl),
    .rise (s_rise),
    .fall (s_fall)
  );

  spi_rdy_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .spi_act (s_fall[I_SS]),
    .uart_act(s_fall[I_URX]),
    .sel     (sel)
  );

  assign if_spi  = (sel == IF_SPI);
  assign if_uart = (sel == IF_UART);
  assign active  = if_spi & ~s_lvl[I_SS];
  assign tx_src  = tx_pick(rsp_pend, rsp_q);

  spi_rdy_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .sck_rise(s_rise[I_SCK]),
    .sck_fall(s_fall[I_SCK]),
    .mosi_s  (s_lvl[I_MOSI]),
    .tx_src  (tx_src),
    .rx_done (rx_done),
    .rx_byte (rx_byte),
    .tx_load (tx_load),
    .miso    (spi_miso)
  );

  assign spi_miso_oe  = active;
  assign rdy_pull_low = cmd_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else if (rx_done) begin
      cmd_valid <= 1'b1;
      cmd_byte  <= rx_byte;
    end else if (cmd_ack) begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q    <= '0;
      rsp_pend <= 1'b0;
    end else if (rsp_we) begin
      rsp_q    <= rsp_byte;
      rsp_pend <= 1'b1;
    end else if (tx_load) begin
      rsp_pend <= 1'b0;
    end
  end

  AST_RDY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rdy_pull_low); // R3

  AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_pull_low && !cmd_ack) |=> rdy_pull_low); // R3

  AST_MISO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    s_lvl[I_SS] |-> !spi_miso_oe); // R6

  AST_UART_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    if_uart |-> (!rx_done && !spi_miso_oe)); // R9

  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !rsp_pend && !rsp_we) |=> !spi_miso); // R5

endmodule

// File: tb/spi_ready_slave_tb.sv
module spi_ready_slave_tb;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b1, spi_mosi = 1'b1, spi_ss_n = 1'b1, uart_rx = 1'b1;
  logic       cmd_ack = 1'b0, rsp_we = 1'b0;
  logic [7:0] rsp_byte = 8'h00;
  logic       spi_miso, spi_miso_oe, rdy_pull_low, cmd_valid, if_spi, if_uart;
  logic [7:0] cmd_byte;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_miso;
  bit oe_bad;

  always #5 clk = ~clk;

  spi_ready_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_ss_n(spi_ss_n), .uart_rx(uart_rx), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .rdy_pull_low(rdy_pull_low),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ack(cmd_ack),
    .rsp_we(rsp_we), .rsp_byte(rsp_byte), .if_spi(if_spi), .if_uart(if_uart)
  );

  function automatic logic [7:0] resp_of(input logic [7:0] c);
    return {c[3:0], c[7:4]} ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    spi_sck = 1'b1; spi_mosi = 1'b1; spi_ss_n = 1'b1; uart_rx = 1'b1;
    cmd_ack = 1'b0; rsp_we = 1'b0;
    rst_n = 1'b0;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
  endtask

  // Host transfer of nbits; returns bits seen on MISO before each rising edge.
  task automatic host_xfer(input logic [7:0] d, input int nbits, output logic [7:0] got);
    got = 8'h00;
    oe_bad = 1'b0;
    spi_ss_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nbits; i++) begin
      spi_sck = 1'b0;
      spi_mosi = d[7-i];
      wclk(HALF);
      got[7-i] = spi_miso;
      if (spi_miso_oe !== 1'b1) oe_bad = 1'b1;
      spi_sck = 1'b1;
      wclk(HALF);
    end
    spi_ss_n = 1'b1;
    wclk(HALF);
  endtask

  task automatic core_serve(input logic [7:0] d, input bit give_rsp);
    check(cmd_valid === 1'b1, "R2 cmd_valid", cmd_valid, 1);
    check(cmd_byte === d, "R2 cmd_byte", cmd_byte, d);
    check(rdy_pull_low === 1'b1, "R3 ready low after byte", rdy_pull_low, 1);
    wclk(2);
    check(rdy_pull_low === 1'b1, "R3 ready held until ack", rdy_pull_low, 1);
    if (give_rsp) begin
      rsp_byte = resp_of(d);
      rsp_we = 1'b1;
      wclk(1);
      rsp_we = 1'b0;
      exp_miso = resp_of(d);
    end else begin
      exp_miso = 8'h00;
    end
    cmd_ack = 1'b1;
    wclk(1);
    cmd_ack = 1'b0;
    check(rdy_pull_low === 1'b0, "R3 ready released after ack", rdy_pull_low, 0);
  endtask

  task automatic full_byte(input logic [7:0] d, input bit give_rsp);
    logic [7:0] got;
    host_xfer(d, 8, got);
    if (exp_miso == 8'h00)
      check(got === exp_miso, "R5 zero fill", got, exp_miso);
    else
      check(got === exp_miso, "R4 response bits", got, exp_miso);
    check(!oe_bad, "R6 miso driven during select", oe_bad, 0);
    check(spi_miso_oe === 1'b0, "R6 miso released after select", spi_miso_oe, 0);
    core_serve(d, give_rsp);
  endtask

  initial begin
    logic [7:0] got;
    void'($urandom(32'd1234));
    exp_miso = 8'h00;

    // Reset state, then UART-first lock
    do_reset();
    check(rdy_pull_low === 1'b0, "R1 ready released", rdy_pull_low, 0);
    check(cmd_valid === 1'b0, "R1 no command", cmd_valid, 0);
    check(spi_miso_oe === 1'b0, "R1 miso off", spi_miso_oe, 0);
    check(if_spi === 1'b0 && if_uart === 1'b0, "R1 unlocked", {if_spi, if_uart}, 0);
    uart_rx = 1'b0; wclk(6); uart_rx = 1'b1; wclk(4);
    check(if_uart === 1'b1 && if_spi === 1'b0, "R9 uart locked", {if_spi, if_uart}, 1);
    host_xfer(8'h3C, 8, got);
    check(cmd_valid === 1'b0, "R9 spi ignored", cmd_valid, 0);
    check(rdy_pull_low === 1'b0, "R9 ready untouched", rdy_pull_low, 0);
    check(!oe_bad || spi_miso_oe === 1'b0, "R9 miso never driven", oe_bad, 0);
    check(oe_bad == 1'b0 ? 1'b0 : 1'b1, "R9 miso never driven", oe_bad, 0);
    check(if_uart === 1'b1, "R9 uart stays locked", if_uart, 1);

    // Simultaneous activity: SPI wins
    do_reset();
    spi_ss_n = 1'b0; uart_rx = 1'b0; wclk(6);
    check(if_spi === 1'b1 && if_uart === 1'b0, "R10 spi priority", {if_spi, if_uart}, 2);
    spi_ss_n = 1'b1; uart_rx = 1'b1; wclk(4);

    // SPI-first lock and traffic
    do_reset();
    exp_miso = 8'h00;
    full_byte(8'h80, 1'b1);
    check(if_spi === 1'b1, "R8 spi locked", if_spi, 1);
    full_byte(8'h01, 1'b1);
    full_byte(8'hFF, 1'b0);
    full_byte(8'h00, 1'b1);
    uart_rx = 1'b0; wclk(6); uart_rx = 1'b1; wclk(4);
    check(if_spi === 1'b1 && if_uart === 1'b0, "R8 lock survives uart activity", {if_spi, if_uart}, 2);

    // Directed partial byte followed by aligned full byte
    host_xfer(8'hF0, 3, got);
    exp_miso = 8'h00;
    check(cmd_valid === 1'b0, "R7 partial dropped", cmd_valid, 0);
    check(rdy_pull_low === 1'b0, "R7 ready untouched", rdy_pull_low, 0);
    full_byte(8'h5A, 1'b1);

    // Constrained random traffic
    for (int k = 0; k < 60; k++) begin
      int kind;
      logic [7:0] d;
      kind = int'($urandom % 8);
      d = 8'($urandom);
      if (kind == 0) begin
        host_xfer(d, 1 + int'($urandom % 7), got);
        exp_miso = 8'h00;
        check(cmd_valid === 1'b0, "R7 random partial dropped", cmd_valid, 0);
      end else begin
        full_byte(d, ($urandom % 4) != 0);
      end
    end
    full_byte(8'hC3, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule